// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Timing

This block is a first-in first-out buffer between two unrelated clock domains. Words of `DW` bits are pushed on the write clock and popped on the read clock. Each pointer crosses into the other domain as Gray code through a short chain of flops. An extra wrap bit on each pointer separates a full buffer from an empty one. The storage holds `DEPTH` words, and `DEPTH` must be a power of two.

A mode pin is captured while master reset is held, and that choice stays until the next master reset. It selects one of two read disciplines. In requested mode, every word, the first one included, leaves the buffer only on a read edge with read enable low. In fall-through mode, the head word is moved into the output register without any request. The output register then counts as one extra slot, so the total capacity is `DEPTH+1`. The two status pins change meaning and polarity with the mode.

A partial reset empties the buffer and keeps the captured mode. A retransmit request, taken on the read clock, rewinds only the read side to the first stored location so that the stored data can be read out again.

Top module: `dcf_fifo`

## Requirements
- R1: `mode_sel` is captured only while `mrst_n` is low (0 = requested mode, 1 = fall-through mode). A partial reset (`prst_n` low) does not change the captured mode.
- R2: After either reset, `dout` is all zeros and the FIFO is empty. In requested mode this means `rd_stat`=0 and `wr_stat`=1. In fall-through mode it means `rd_stat`=1 and `wr_stat`=0.
- R3: In requested mode, `dout` changes only on a read clock edge where `ren_n` is 0 and the FIFO holds data. `rd_stat` reads 1 once a word is stored and 0 after the last word is taken.
- R4: In requested mode, `wr_stat` goes to 0 after exactly `DEPTH` writes with no reads. A single read returns it to 1.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `dout` with no read request. This happens within three read clock rising edges after the write edge. `rd_stat` is 0 while `dout` holds a valid word and 1 after the last word is popped.
- R6: In fall-through mode, `wr_stat` goes to 1 (no space) after `DEPTH+1` writes with no reads.
- R7: `ren_n` low has no effect while the FIFO is empty, and a write attempted while full is discarded.
- R8: `rexmit_n` low on a read clock edge rewinds the read pointer to location 0. It leaves the write pointer unchanged and, for one read cycle, reports the buffer as empty (`rd_stat`=0 in requested mode, 1 in fall-through mode). After that, the stored words are read again from the first one.
- R9: Across unrelated clock ratios, in both modes, every accepted word is delivered exactly once and in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, keeps the captured mode |
| mode_sel | input | 1 | Timing mode, sampled during master reset (1 = fall-through) |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| wr_stat | output | 1 | Requested mode: 0 = full. Fall-through mode: 1 = no space |
| ren_n | input | 1 | Read enable, active low |
| rexmit_n | input | 1 | Retransmit request, active low, sampled on rclk |
| dout | output | DW | Output data register |
| rd_stat | output | 1 | Requested mode: 1 = data stored. Fall-through mode: 0 = dout valid |

## Verification
The bench goes after the capacity edge in each mode. A design that forgets the output register's slot in fall-through mode reports full one word early. A design that lets writes pass while full overwrites unread data, which shows up when the buffer is drained and compared in order.

It also probes the difference between the two resets. A partial reset that reloads the mode would turn the fall-through behaviour off. Retransmit is checked by re-reading the stored words, which would fail if the write pointer were also cleared.

Streams under several clock ratios catch lost or repeated words caused by a wrongly synchronized pointer or a mistimed status.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_REQ = 1'b0,
    MODE_FT  = 1'b1
  } dcf_mode_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= gray_in;
        else         stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    bin_out[W-1] = stage_q[STAGES-1][W-1];
    for (int i = W-2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mst_n,
  input  logic          mode_sel,
  input  logic          wen_n,
  input  logic [PW-1:0] rbin_s,
  output logic [AW-1:0] waddr,
  output logic          wr_en,
  output logic [PW-1:0] wgray,
  output logic          wr_stat
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  dcf_mode_e     mode_q;
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [PW-1:0] fill;
  logic          full;

  // mode register: clock enable is the held master reset
  always_ff @(posedge clk) begin
    if (!mst_n) mode_q <= dcf_mode_e'(mode_sel);
  end

  always_comb begin
    fill    = wptr_q - rbin_s;
    full    = (fill == CAP);
    wr_en   = !wen_n && !full;
    wptr_d  = wptr_q + PW'(wr_en);
    wgray_d = wptr_d ^ (wptr_d >> 1);
    wr_stat = (mode_q == MODE_FT) ? full : !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wptr_q[AW-1:0];
  assign wgray = wgray_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q - rbin_s) <= CAP);

  // R1
  wmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_n && $past(mst_n)) |-> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mst_n,
  input  logic          mode_sel,
  input  logic          ren_n,
  input  logic          rexmit_n,
  input  logic [PW-1:0] wbin_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          rd_stat
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  dcf_mode_e     mode_q;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [PW-1:0] rgray_q, rgray_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          valid_q, valid_d;
  logic          hold_q, hold_d;
  logic          mem_empty;
  logic          load;

  always_ff @(posedge clk) begin
    if (!mst_n) mode_q <= dcf_mode_e'(mode_sel);
  end

  always_comb begin
    mem_empty = (rptr_q == wbin_s);
    rptr_d    = rptr_q;
    valid_d   = valid_q;
    dout_d    = dout_q;
    hold_d    = 1'b0;
    load      = 1'b0;
    if (!rexmit_n) begin
      rptr_d  = '0;
      valid_d = 1'b0;
      hold_d  = 1'b1;
    end else if (mode_q == MODE_REQ) begin
      load = !ren_n && !mem_empty && !hold_q;
    end else begin
      load = !mem_empty && !hold_q && (!valid_q || !ren_n);
      if (!load && !ren_n) valid_d = 1'b0;
    end
    if (load) begin
      dout_d  = rdata;
      rptr_d  = rptr_q + 1'b1;
      valid_d = (mode_q == MODE_FT);
    end
    rgray_d = rptr_d ^ (rptr_d >> 1);
    rd_stat = (mode_q == MODE_FT) ? !valid_q : !(mem_empty || hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      rgray_q <= rgray_d;
      dout_q  <= dout_d;
      valid_q <= valid_d;
      hold_q  <= hold_d;
    end
  end

  assign raddr = rptr_q[AW-1:0];
  assign rgray = rgray_q;
  assign dout  = dout_q;

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_s - rptr_q) <= CAP);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_REQ && (ren_n || mem_empty || hold_q)) |=> $stable(dout_q));

  // R5
  ft_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FT && valid_q && ren_n && rexmit_n) |=> ($stable(dout_q) && valid_q));

  // R8
  rexmit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rexmit_n |=> (rptr_q == '0 && !valid_q));

  // R1
  rmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_n && $past(mst_n)) |-> $stable(mode_q));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW     = 18,
  parameter int DEPTH  = 16,
  parameter int SYNC_N = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  output logic          wr_stat,
  input  logic          ren_n,
  input  logic          rexmit_n,
  output logic [DW-1:0] dout,
  output logic          rd_stat
);
  logic          any_rst_n;
  logic          w_rst_n, w_mst_n, r_rst_n, r_mst_n;
  logic [PW-1:0] wgray, rgray, wbin_s, rbin_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_en;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata;

  assign any_rst_n = mrst_n & prst_n;

  dcf_rst_sync #(.STAGES(SYNC_N)) u_wrst (.clk(wclk), .arst_n(any_rst_n), .srst_n(w_rst_n));
  dcf_rst_sync #(.STAGES(SYNC_N)) u_wmst (.clk(wclk), .arst_n(mrst_n),    .srst_n(w_mst_n));
  dcf_rst_sync #(.STAGES(SYNC_N)) u_rrst (.clk(rclk), .arst_n(any_rst_n), .srst_n(r_rst_n));
  dcf_rst_sync #(.STAGES(SYNC_N)) u_rmst (.clk(rclk), .arst_n(mrst_n),    .srst_n(r_mst_n));

  dcf_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
    .clk(wclk), .rst_n(w_rst_n), .gray_in(rgray), .bin_out(rbin_s));
  dcf_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
    .clk(rclk), .rst_n(r_rst_n), .gray_in(wgray), .bin_out(wbin_s));

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .mst_n(w_mst_n), .mode_sel(mode_sel),
    .wen_n(wen_n), .rbin_s(rbin_s), .waddr(waddr), .wr_en(wr_en),
    .wgray(wgray), .wr_stat(wr_stat));

  dcf_rd_ctl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .mst_n(r_mst_n), .mode_sel(mode_sel),
    .ren_n(ren_n), .rexmit_n(rexmit_n), .wbin_s(wbin_s), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .dout(dout), .rd_stat(rd_stat));

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= din;
  end

  assign rdata = mem[raddr];
endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int DEPTH = 16;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, rexmit_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic wr_stat, rd_stat;
  int rhalf = 7;
  int n_chk = 0, n_fail = 0;
  logic cur_mode = 1'b0;

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .wen_n(wen_n), .din(din), .wr_stat(wr_stat),
    .ren_n(ren_n), .rexmit_n(rexmit_n), .dout(dout), .rd_stat(rd_stat));

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit has_space();
    return cur_mode ? (wr_stat == 1'b0) : (wr_stat == 1'b1);
  endfunction

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_mreset(input logic m);
    mode_sel = m; mrst_n = 1'b0;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    mrst_n = 1'b1; cur_mode = m;
    settle();
  endtask

  task automatic wr(input logic [DW-1:0] d);
    for (int k = 0; k < 200; k++) begin
      @(negedge wclk);
      if (has_space()) break;
    end
    wen_n = 1'b0; din = d;
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic wr_force(input logic [DW-1:0] d);
    @(negedge wclk);
    wen_n = 1'b0; din = d;
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic rd_req(output logic [DW-1:0] d);
    @(negedge rclk); ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1;
    d = dout;
  endtask

  task automatic rd_ft(output logic [DW-1:0] d);
    for (int k = 0; k < 200; k++) begin
      @(negedge rclk);
      if (rd_stat == 1'b0) break;
    end
    d = dout;
    ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1;
  endtask

  task automatic rexmit_pulse();
    @(negedge rclk); rexmit_n = 1'b0;
    @(negedge rclk); rexmit_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    do_mreset(1'b0);
    chk(dout == '0, "R2 dout zero req", dout, 0);
    chk(rd_stat == 1'b0 && wr_stat == 1'b1, "R2 flags req", {rd_stat, wr_stat}, 2'b01);
    do_mreset(1'b1);
    chk(dout == '0, "R2 dout zero ft", dout, 0);
    chk(rd_stat == 1'b1 && wr_stat == 1'b0, "R2 flags ft", {rd_stat, wr_stat}, 2'b10);
    d = '0;
  endtask

  task automatic t_req_basic();
    logic [DW-1:0] d;
    do_mreset(1'b0);
    for (int i = 0; i < 3; i++) wr(18'h100 + 18'(i));
    settle();
    chk(rd_stat == 1'b1, "R3 not empty", rd_stat, 1);
    chk(dout == '0, "R3 no fall-through", dout, 0);
    for (int i = 0; i < 3; i++) begin
      rd_req(d);
      chk(d == 18'h100 + 18'(i), "R3 data order", d, 18'h100 + i);
    end
    settle();
    chk(rd_stat == 1'b0, "R3 empty after last", rd_stat, 0);
    rd_req(d);
    chk(dout == 18'h102 && rd_stat == 1'b0, "R7 read on empty ignored", dout, 18'h102);
  endtask

  task automatic t_req_full();
    logic [DW-1:0] d;
    do_mreset(1'b0);
    for (int i = 0; i < DEPTH - 1; i++) wr(18'h200 + 18'(i));
    chk(wr_stat == 1'b1, "R4 not full at DEPTH-1", wr_stat, 1);
    wr(18'h200 + 18'(DEPTH - 1));
    chk(wr_stat == 1'b0, "R4 full at DEPTH", wr_stat, 0);
    wr_force(18'h3BAD);
    settle();
    rd_req(d);
    chk(d == 18'h200, "R4 first word", d, 18'h200);
    settle();
    chk(wr_stat == 1'b1, "R4 space after one read", wr_stat, 1);
    for (int i = 1; i < DEPTH; i++) begin
      rd_req(d);
      chk(d == 18'h200 + 18'(i), "R7 full write discarded", d, 18'h200 + i);
    end
    settle();
    chk(rd_stat == 1'b0, "R7 drained exactly DEPTH", rd_stat, 0);
  endtask

  task automatic t_ft_basic();
    logic [DW-1:0] d;
    int n;
    do_mreset(1'b1);
    wr(18'h0ABC);
    n = 0;
    while (rd_stat != 1'b0 && n < 10) begin
      @(posedge rclk); #1; n++;
    end
    chk(n <= 3, "R5 fall-through latency", n, 3);
    chk(dout == 18'h0ABC, "R5 word without request", dout, 18'h0ABC);
    rd_ft(d);
    settle();
    chk(rd_stat == 1'b1, "R5 not ready after last pop", rd_stat, 1);
    rd_req(d);
    chk(dout == 18'h0ABC && rd_stat == 1'b1, "R7 pop on empty ignored ft", dout, 18'h0ABC);
  endtask

  task automatic t_ft_full();
    logic [DW-1:0] d;
    do_mreset(1'b1);
    wr(18'h300);
    settle();
    for (int i = 1; i < DEPTH; i++) wr(18'h300 + 18'(i));
    chk(wr_stat == 1'b0, "R6 space left at DEPTH", wr_stat, 0);
    wr(18'h300 + 18'(DEPTH));
    settle();
    chk(wr_stat == 1'b1, "R6 full at DEPTH+1", wr_stat, 1);
    wr_force(18'h3BAD);
    for (int i = 0; i <= DEPTH; i++) begin
      rd_ft(d);
      chk(d == 18'h300 + 18'(i), "R6 drain order", d, 18'h300 + i);
    end
    settle();
    chk(rd_stat == 1'b1, "R7 extra write dropped ft", rd_stat, 1);
  endtask

  task automatic t_rexmit_req();
    logic [DW-1:0] d;
    do_mreset(1'b0);
    for (int i = 0; i < 4; i++) wr(18'h400 + 18'(i));
    settle();
    rd_req(d); rd_req(d);
    rexmit_pulse();
    chk(rd_stat == 1'b0, "R8 forced empty req", rd_stat, 0);
    settle();
    for (int i = 0; i < 4; i++) begin
      rd_req(d);
      chk(d == 18'h400 + 18'(i), "R8 reread req", d, 18'h400 + i);
    end
    settle();
    chk(rd_stat == 1'b0, "R8 write pointer kept", rd_stat, 0);
  endtask

  task automatic t_rexmit_ft();
    logic [DW-1:0] d;
    do_mreset(1'b1);
    for (int i = 0; i < 3; i++) wr(18'h500 + 18'(i));
    settle();
    rd_ft(d); rd_ft(d);
    rexmit_pulse();
    chk(rd_stat == 1'b1, "R8 forced not ready ft", rd_stat, 1);
    settle();
    chk(dout == 18'h500 && rd_stat == 1'b0, "R8 first word back ft", dout, 18'h500);
    for (int i = 0; i < 3; i++) begin
      rd_ft(d);
      chk(d == 18'h500 + 18'(i), "R8 reread ft", d, 18'h500 + i);
    end
  endtask

  task automatic t_partial();
    do_mreset(1'b1);
    wr(18'h111); wr(18'h222);
    settle();
    chk(dout == 18'h111, "R5 head shown", dout, 18'h111);
    mode_sel = 1'b0; prst_n = 1'b0;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    prst_n = 1'b1;
    settle();
    chk(dout == '0 && rd_stat == 1'b1, "R2 partial reset clears", dout, 0);
    wr(18'h333);
    settle();
    chk(dout == 18'h333 && rd_stat == 1'b0, "R1 mode kept over partial reset", dout, 18'h333);
    mode_sel = 1'b0;
  endtask

  task automatic t_stream(input logic m, input int rh);
    int got, errs, issued;
    localparam int N = 60;
    rhalf = rh;
    do_mreset(m);
    got = 0; errs = 0; issued = 0;
    fork
      begin
        int i = 0;
        for (int c = 0; c < 4000 && i < N; c++) begin
          @(negedge wclk);
          if (has_space()) begin
            wen_n = 1'b0; din = 18'h1000 + 18'(i); i++;
          end else wen_n = 1'b1;
          if (c % 7 == 3) begin @(negedge wclk); wen_n = 1'b1; end
        end
        @(negedge wclk); wen_n = 1'b1;
      end
      begin
        bit pend = 1'b0;
        for (int c = 0; c < 4000 && got < N; c++) begin
          @(negedge rclk);
          if (m == 1'b0) begin
            if (pend) begin
              if (dout != 18'h1000 + 18'(got)) errs++;
              got++; pend = 1'b0;
            end
            if (rd_stat == 1'b1 && issued < N && (c % 5 != 2)) begin
              ren_n = 1'b0; pend = 1'b1; issued++;
            end else ren_n = 1'b1;
          end else begin
            if (rd_stat == 1'b0 && got < N && (c % 5 != 2)) begin
              if (dout != 18'h1000 + 18'(got)) errs++;
              got++; ren_n = 1'b0;
            end else ren_n = 1'b1;
          end
        end
        @(negedge rclk); ren_n = 1'b1;
      end
    join
    chk(got == N && errs == 0, "R9 stream order and count", got, N);
    settle();
    chk(rd_stat == (m ? 1'b1 : 1'b0), "R9 nothing left over", rd_stat, m ? 1 : 0);
    rhalf = 7;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_req_basic();
    t_req_full();
    t_ft_basic();
    t_ft_full();
    t_rexmit_req();
    t_rexmit_ft();
    t_partial();
    t_stream(1'b0, 3);
    t_stream(1'b1, 3);
    t_stream(1'b0, 13);
    t_stream(1'b1, 11);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule